// File: doc/BRIEF.md
# Quasi-Bidirectional Latched I/O Port

This block is a general-purpose parallel port for a small microcontroller. Each pin has one output-latch bit. A pin is never driven high by a strong driver. A latch 0 turns on a drive-low enable for that pin. A latch 1 releases the pin, and a weak pull-up then holds it high, so the pin can also serve as an input. No separate direction register exists: a pin's direction follows its latch bit. Software makes a pin an input by writing a 1 to its latch bit.

The CPU side has four kinds of access:
- **Plain write.** Loads the whole latch.
- **Read-modify-write.** Combines the latch (never the pins) with an operand and writes the result back to the latch.
- **Bit operations.** Set or clear one latch bit without touching the others.
- **Reads.** The read port returns either the synchronized pin levels or the latch. A single-bit test output uses the same source.

A configuration input selects open-drain operation, which removes the internal pull-up. An alternate-function input hands the pins to an external memory controller. In that mode the pins carry the low address byte and then the data byte of a memory cycle, while the latch keeps its contents.

Top module: `qbio_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, every latch bit is 1. The pad outputs show no drive-low enable, and all pull-ups are enabled when `open_drain` is 0. The pin synchronizer also resets to all ones.
- R2: Outside alternate mode, `pin_drive_low[i]` is the inverse of latch bit i. Writing 0 makes the pin drive low, and writing 1 releases it.
- R3: With `rd_sel`=0, `rd_data` returns `pin_in` as it stood two rising clock edges earlier, after a two-stage synchronizer.
- R4: With `rd_sel`=1, `rd_data` returns the current latch contents.
- R5: When `rmw_en` is high, the latch at the next edge becomes f(latch, `rmw_operand`). The encoding of `rmw_op` is: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 AND with the inverted operand (clear mask). The operation reads the latch and never the pins.
- R6: If `rmw_en` and `wr_en` are both high in one cycle, the read-modify-write result is stored and `wr_data` is ignored. Otherwise `wr_en` loads `wr_data`.
- R7: With neither `wr_en` nor `rmw_en` high, `bit_set` sets latch bit `bit_idx` and `bit_clr` clears it. The other bits are unchanged. If both are high, the set wins. Bit operations are ignored in a cycle that has a write or a read-modify-write.
- R8: With `open_drain`=1, `pin_pullup` is all zeros in every mode, and `pin_drive_low` is unaffected.
- R9: With `open_drain`=0, outside alternate mode, `pin_pullup` equals the latch.
- R10: With `alt_en`=1, the pad value is `alt_addr` when `alt_addr_phase`=1 and `alt_data` otherwise. The drive-low enable is the inverse of that value, and the pull-up equals that value (zero in open-drain mode). The latch is not changed by the mode.
- R11: `bit_test` returns bit `bit_idx` of the source that `rd_sel` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Plain latch write |
| wr_data | input | W | Value for plain write |
| rmw_en | input | 1 | Read-modify-write strobe |
| rmw_op | input | 2 | Read-modify-write operation code |
| rmw_operand | input | W | Read-modify-write operand |
| bit_set | input | 1 | Set one latch bit |
| bit_clr | input | 1 | Clear one latch bit |
| bit_idx | input | IDX_W | Bit selected for set, clear and test |
| rd_sel | input | 1 | Read source: 0 pins, 1 latch |
| rd_data | output | W | Read data |
| bit_test | output | 1 | Tested bit of the read source |
| open_drain | input | 1 | Removes internal pull-ups |
| alt_en | input | 1 | Alternate-function mode |
| alt_addr_phase | input | 1 | 1 address phase, 0 data phase |
| alt_addr | input | W | Low address byte from memory controller |
| alt_data | input | W | Data byte from memory controller |
| pin_in | input | W | Sampled pad levels |
| pin_drive_low | output | W | Pad drive-low enables |
| pin_pullup | output | W | Pad weak pull-up enables |

## Verification
The bench builds the port with its defaults: W=8 and a synchronizer depth of 2. The 8-bit width keeps every bit index, including the top bit 7, reachable by the bit set, clear and test paths. The two-stage depth makes the pin-read latency a fixed two-edge delay, which a short history queue in the model can follow. The directed and random phases bring collisions of write, read-modify-write and bit operations, all four operation codes, open-drain mode combined with alternate mode, and phase switching within reach in a few hundred cycles.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  typedef enum logic [1:0] {
    RMW_AND  = 2'b00,
    RMW_OR   = 2'b01,
    RMW_XOR  = 2'b10,
    RMW_CLRM = 2'b11
  } rmw_op_e;

  localparam int unsigned FN_W = 32;

  // Combines latch contents with an operand; the operand never sees pin levels.
  function automatic logic [FN_W-1:0] rmw_apply(input logic [1:0] op,
                                                input logic [FN_W-1:0] cur,
                                                input logic [FN_W-1:0] opnd);
    case (rmw_op_e'(op))
      RMW_AND: rmw_apply = cur & opnd;
      RMW_OR:  rmw_apply = cur | opnd;
      RMW_XOR: rmw_apply = cur ^ opnd;
      default: rmw_apply = cur & ~opnd;
    endcase
  endfunction

  // One-hot mask for a bit index, empty when the index is past the width.
  function automatic logic [FN_W-1:0] bit_mask(input int unsigned idx,
                                               input int unsigned width);
    bit_mask = '0;
    if (idx < width) bit_mask[idx] = 1'b1;
  endfunction
endpackage

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/qbio_latch.sv
module qbio_latch #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rmw_en,
  input  logic [1:0]       rmw_op,
  input  logic [W-1:0]     rmw_operand,
  input  logic             bit_set,
  input  logic             bit_clr,
  input  logic [IDX_W-1:0] bit_idx,
  output logic [W-1:0]     latch_q
);
  import qbio_pkg::*;

  logic [W-1:0] rmw_val, sel_mask, latch_d;

  assign rmw_val  = W'(rmw_apply(rmw_op, FN_W'(latch_q), FN_W'(rmw_operand)));
  assign sel_mask = W'(bit_mask(int'(bit_idx), W));

  always_comb begin
    latch_d = latch_q;
    if (rmw_en)       latch_d = rmw_val;
    else if (wr_en)   latch_d = wr_data;
    else if (bit_set) latch_d = latch_q | sel_mask;
    else if (bit_clr) latch_d = latch_q & ~sel_mask;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) latch_q <= '1;
    else        latch_q <= latch_d;
endmodule

// File: rtl/qbio_padctl.sv
module qbio_padctl #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] latch_q,
  input  logic         open_drain,
  input  logic         alt_en,
  input  logic         alt_addr_phase,
  input  logic [W-1:0] alt_addr,
  input  logic [W-1:0] alt_data,
  output logic [W-1:0] pad_val,
  output logic [W-1:0] pin_drive_low,
  output logic [W-1:0] pin_pullup
);
  logic [W-1:0] alt_val;

  assign alt_val       = alt_addr_phase ? alt_addr : alt_data;
  assign pad_val       = alt_en ? alt_val : latch_q;
  assign pin_drive_low = ~pad_val;
  assign pin_pullup    = open_drain ? '0 : pad_val;
endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rmw_en,
  input  logic [1:0]       rmw_op,
  input  logic [W-1:0]     rmw_operand,
  input  logic             bit_set,
  input  logic             bit_clr,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             rd_sel,
  output logic [W-1:0]     rd_data,
  output logic             bit_test,
  input  logic             open_drain,
  input  logic             alt_en,
  input  logic             alt_addr_phase,
  input  logic [W-1:0]     alt_addr,
  input  logic [W-1:0]     alt_data,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_drive_low,
  output logic [W-1:0]     pin_pullup
);
  // Named internal events for the checker.
  logic [W-1:0] latch_q;
  logic [W-1:0] pin_sync_q;
  logic [W-1:0] pad_val;
  logic         rmw_fire, wr_fire, bitop_fire;

  assign rmw_fire   = rmw_en;
  assign wr_fire    = wr_en & ~rmw_en;
  assign bitop_fire = (bit_set | bit_clr) & ~wr_en & ~rmw_en;

  qbio_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync_q)
  );

  qbio_latch #(.W(W), .IDX_W(IDX_W)) latch_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx),
    .latch_q(latch_q)
  );

  qbio_padctl #(.W(W)) pad_i (
    .latch_q(latch_q), .open_drain(open_drain),
    .alt_en(alt_en), .alt_addr_phase(alt_addr_phase),
    .alt_addr(alt_addr), .alt_data(alt_data),
    .pad_val(pad_val),
    .pin_drive_low(pin_drive_low), .pin_pullup(pin_pullup)
  );

  assign rd_data  = rd_sel ? latch_q : pin_sync_q;
  assign bit_test = (int'(bit_idx) < W) ? rd_data[bit_idx] : 1'b0;
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rmw_en,
  input logic [1:0]       rmw_op,
  input logic [W-1:0]     rmw_operand,
  input logic             wr_en,
  input logic             bit_set,
  input logic             bit_clr,
  input logic [IDX_W-1:0] bit_idx,
  input logic             open_drain,
  input logic             alt_en,
  input logic [W-1:0]     pin_in,
  input logic [W-1:0]     latch_q,
  input logic [W-1:0]     pin_sync_q,
  input logic [W-1:0]     pin_drive_low,
  input logic [W-1:0]     pin_pullup
);
  logic [1:0]   age_q;
  logic [W-1:0] idx_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;

  always_comb begin
    idx_mask = '0;
    if (int'(bit_idx) < W) idx_mask[bit_idx] = 1'b1;
  end

  // R2
  drive_follows_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_en |-> pin_drive_low == ~latch_q);

  // R8
  od_no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_drain |-> pin_pullup == '0);

  // R9
  pullup_follows_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_drain && !alt_en) |-> pin_pullup == latch_q);

  // R3
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> pin_sync_q == $past(pin_in, 2));

  // R5
  rmw_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_en && rmw_op == 2'b00) |=> latch_q == ($past(latch_q) & $past(rmw_operand)));

  // R6
  rmw_or_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_en && wr_en && rmw_op == 2'b01) |=> latch_q == ($past(latch_q) | $past(rmw_operand)));

  // R7
  bitop_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bit_set || bit_clr) && !wr_en && !rmw_en)
      |=> (latch_q & ~$past(idx_mask)) == ($past(latch_q) & ~$past(idx_mask)));

  // R7
  bitset_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_set && !wr_en && !rmw_en) |=> (latch_q & $past(idx_mask)) == $past(idx_mask));
endmodule

bind qbio_port qbio_port_chk #(.W(W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rmw_en(rmw_en), .rmw_op(rmw_op),
  .rmw_operand(rmw_operand), .wr_en(wr_en), .bit_set(bit_set),
  .bit_clr(bit_clr), .bit_idx(bit_idx), .open_drain(open_drain),
  .alt_en(alt_en), .pin_in(pin_in), .latch_q(latch_q),
  .pin_sync_q(pin_sync_q), .pin_drive_low(pin_drive_low),
  .pin_pullup(pin_pullup)
);

// File: tb/qbio_port_tb_top.sv
module qbio_port_tb_top;
  localparam int CLK_HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, rmw_en = 0, bit_set = 0, bit_clr = 0, rd_sel = 0;
  logic       open_drain = 0, alt_en = 0, alt_addr_phase = 0;
  logic [1:0] rmw_op = 0;
  logic [2:0] bit_idx = 0;
  logic [7:0] wr_data = 0, rmw_operand = 0, alt_addr = 0, alt_data = 0;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] rd_data, pin_drive_low, pin_pullup;
  logic       bit_test;

  int vectors = 0;
  int miscompares = 0;

  byte unsigned m_latch = 8'hFF;
  byte unsigned pin_hist[$] = '{8'hFF, 8'hFF};

  always #(CLK_HALF) clk = ~clk;

  qbio_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx),
    .rd_sel(rd_sel), .rd_data(rd_data), .bit_test(bit_test),
    .open_drain(open_drain), .alt_en(alt_en), .alt_addr_phase(alt_addr_phase),
    .alt_addr(alt_addr), .alt_data(alt_data), .pin_in(pin_in),
    .pin_drive_low(pin_drive_low), .pin_pullup(pin_pullup)
  );

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    byte unsigned src, padv, exp_pu;
    src    = rd_sel ? m_latch : pin_hist[0];
    padv   = alt_en ? (alt_addr_phase ? alt_addr : alt_data) : m_latch;
    exp_pu = open_drain ? 8'h00 : padv;
    cmp(rd_sel ? "R4" : "R3", "rd_data", int'(rd_data), int'(src));
    cmp("R11", "bit_test", int'(bit_test), int'((src >> bit_idx) & 1));
    cmp(alt_en ? "R10" : "R2", "drive_low", int'(pin_drive_low), int'(8'(~padv)));
    cmp(open_drain ? "R8" : (alt_en ? "R10" : "R9"), "pullup", int'(pin_pullup), int'(exp_pu));
  endtask

  task automatic model_edge();
    if (rmw_en) begin
      if (rmw_op == 2'b00)      m_latch = m_latch & rmw_operand;
      else if (rmw_op == 2'b01) m_latch = m_latch | rmw_operand;
      else if (rmw_op == 2'b10) m_latch = m_latch ^ rmw_operand;
      else                      m_latch = m_latch & ~rmw_operand;
    end else if (wr_en) begin
      m_latch = wr_data;
    end else if (bit_set) begin
      m_latch = m_latch | (8'd1 << bit_idx);
    end else if (bit_clr) begin
      m_latch = m_latch & ~(8'd1 << bit_idx);
    end
    pin_hist.push_back(pin_in);
    void'(pin_hist.pop_front());
  endtask

  // One clock: inputs already set at a negedge; compare, then step the model.
  task automatic step();
    #1 check_outputs();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; rmw_en = 0; bit_set = 0; bit_clr = 0;
  endtask

  bit done = 0;
  initial begin
    #(2 * CLK_HALF * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and after reset
    @(negedge clk);
    rd_sel = 1;
    #1 cmp("R1", "latch in reset", int'(rd_data), 8'hFF);
    cmp("R1", "drive_low in reset", int'(pin_drive_low), 0);
    cmp("R1", "pullup in reset", int'(pin_pullup), 8'hFF);
    rd_sel = 0;
    #1 cmp("R1", "sync in reset", int'(rd_data), 8'hFF);
    @(negedge clk);
    rst_n = 1;
    step();

    // R2 / R4: plain writes
    wr_en = 1; wr_data = 8'h5A; rd_sel = 1; step();
    idle(); step();
    wr_en = 1; wr_data = 8'hFF; step();
    idle(); step();

    // R3: pin path latency with a changing pattern
    rd_sel = 0;
    for (int k = 0; k < 8; k++) begin
      pin_in = 8'(8'h01 << k) ^ 8'hC3; step();
    end

    // R5: each operation code
    rd_sel = 1;
    wr_en = 1; wr_data = 8'hF0; step(); idle();
    for (int op = 0; op < 4; op++) begin
      rmw_en = 1; rmw_op = 2'(op); rmw_operand = 8'h3C; step();
      rmw_en = 0; step();
    end

    // R5: operand combines with latch, not with differing pins
    pin_in = 8'h00; wr_en = 1; wr_data = 8'hAA; step(); idle();
    rmw_en = 1; rmw_op = 2'b01; rmw_operand = 8'h01; step(); idle(); step();

    // R6: collision of write and read-modify-write
    wr_en = 1; wr_data = 8'h11; rmw_en = 1; rmw_op = 2'b00; rmw_operand = 8'h0F;
    step(); idle(); step();

    // R7: bit set / clear, both, and ignored under a write
    wr_en = 1; wr_data = 8'h00; step(); idle();
    bit_set = 1; bit_idx = 3'd7; step(); idle(); step();
    bit_clr = 1; bit_idx = 3'd7; step(); idle(); step();
    bit_set = 1; bit_clr = 1; bit_idx = 3'd2; step(); idle(); step();
    bit_clr = 1; bit_idx = 3'd2; wr_en = 1; wr_data = 8'h84; step(); idle(); step();
    bit_set = 1; bit_idx = 3'd0; rmw_en = 1; rmw_op = 2'b11; rmw_operand = 8'h80;
    step(); idle(); step();

    // R8 / R9: open drain on and off
    open_drain = 1; step(); step();
    open_drain = 0; step();

    // R10: alternate function, address then data, latch untouched
    alt_en = 1; alt_addr = 8'h3E; alt_data = 8'hC1;
    alt_addr_phase = 1; step();
    alt_addr_phase = 0; step();
    open_drain = 1; step(); open_drain = 0;
    alt_en = 0; step();

    // Random mix over every requirement
    for (int n = 0; n < 600; n++) begin
      wr_en = ($urandom_range(0, 3) == 0);
      wr_data = 8'($urandom);
      rmw_en = ($urandom_range(0, 3) == 0);
      rmw_op = 2'($urandom);
      rmw_operand = 8'($urandom);
      bit_set = ($urandom_range(0, 2) == 0);
      bit_clr = ($urandom_range(0, 2) == 0);
      bit_idx = 3'($urandom);
      rd_sel = 1'($urandom);
      open_drain = ($urandom_range(0, 4) == 0);
      alt_en = ($urandom_range(0, 5) == 0);
      alt_addr_phase = 1'($urandom);
      alt_addr = 8'($urandom);
      alt_data = 8'($urandom);
      pin_in = 8'($urandom);
      step();
    end
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule